// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block moves groups of general registers between a 32-bit CPU's sixteen-entry register file and the stack in memory. Register R15 is the stack pointer. A command carries an 8-bit selection mask. The command code picks the direction and which half of the register file the mask refers to. A pop command moves words from the stack into the selected registers. A push command moves the selected registers onto the stack. The block talks to a word-wide memory port with a request/ready handshake. It uses one combinational read port and one write port on the register file. It also reads R15 through a dedicated input when a command is accepted.

The controller has three states. **ST_IDLE** waits for a command. **ST_XFER** issues one memory request per selected register. **ST_FINISH** writes the updated stack pointer back to R15 and raises `done`.

The transitions are:
- **T_ACCEPT**: ST_IDLE to ST_XFER, when a valid code arrives with a non-empty mask.
- **T_EMPTY**: ST_IDLE to ST_FINISH, when a valid code arrives with an empty mask.
- **T_NEXT**: ST_XFER to ST_XFER, on a completed transfer that leaves registers still to move.
- **T_STALL**: ST_XFER to ST_XFER, while `mem_ready` is low.
- **T_LAST**: ST_XFER to ST_FINISH, when the final transfer completes.
- **T_RETIRE**: ST_FINISH to ST_IDLE.

The stack pointer is held internally while a command runs. R15 is written once, in ST_FINISH.

Top module: `regstack_seq`

## Requirements
- R1: Command codes: 0x8C pops into the low half, 0x8D pops into the high half, 0x8E pushes the low half and 0x8F pushes the high half. Bit 1 of the code selects push (1) or pop (0), and bit 0 selects the high half. Any other code is ignored: `busy` stays low and no register or memory word changes.
- R2: Mask bit i selects register Ri for the low-half codes and register R(8+i) for the high-half codes.
- R3: A pop reads the word at the current stack pointer, writes it to the selected register, and then raises the pointer by 4. Registers are visited from the lowest number upward.
- R4: A push first lowers the pointer by 4 and then writes the register to that address. Registers are visited from the highest number downward. A push of R15 stores the value R15 had before the command.
- R5: A push followed by a pop with the same code half and mask restores every selected register and R15 to their values before the push.
- R6: After a command with n selected registers, R15 equals the starting pointer with bits 1:0 cleared, plus 4n for a pop or minus 4n for a push. Every memory address issued is word-aligned.
- R7: An empty mask keeps `busy` high for exactly one cycle, issues no memory request and leaves R15 unchanged.
- R8: When R15 is in a pop list, R15 ends up holding the word read for it, not the incremented pointer.
- R9: With `mem_ready` held high, `busy` stays high for exactly n+1 cycles. While a request is waiting for `mem_ready`, the address, write flag and write data hold steady and the pointer does not move.
- R10: `done` is high for exactly one cycle, the last cycle of `busy`. A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 8 | Command code |
| cmd_mask | input | 8 | Register selection within the half |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse in the final cycle of a command |
| sp_in | input | 32 | Current value of R15 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
A corrupted remaining-register mask shows up as a wrong `busy` length. It also shows up as a register written out of order or skipped, and either effect is visible within the same command. A corrupted stack pointer shows up on the very next memory request, as a wrong or non-stepping address. If the corruption happens on the last transfer, it appears instead as a wrong R15 value one cycle after `done`. A stuck state register shows up either as `done` not pulsing exactly once or as memory requests continuing after `busy` falls.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } state_t;

    // Upper six bits shared by all four codes; bit1 = push, bit0 = high half.
    localparam logic [5:0] CMD_FAMILY = 6'b100011;
endpackage

// File: rtl/regstack_pick.sv
module regstack_pick #(
    parameter int W         = 8,
    parameter bit LOW_FIRST = 1'b1,
    localparam int IW       = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx
);
    generate
        if (LOW_FIRST) begin : g_low
            always_comb begin
                idx = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end else begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/regstack_sp.sv
module regstack_sp #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [AW-1:0] ALIGN  = ~(STEP_V - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (load) begin
            sp <= load_val & ALIGN;
        end else if (inc) begin
            sp <= sp + STEP_V;
        end else if (dec) begin
            sp <= sp - STEP_V;
        end
    end
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
    import regstack_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int BANK = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [7:0]                cmd_op,
    input  logic [BANK-1:0]           cmd_mask,
    output logic                      busy,
    output logic                      done,
    input  logic [AW-1:0]             sp_in,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic [DW-1:0]             mem_wdata,
    input  logic                      mem_ready,
    input  logic [DW-1:0]             mem_rdata,
    output logic [$clog2(BANK):0]     rf_raddr,
    input  logic [DW-1:0]             rf_rdata,
    output logic                      rf_we,
    output logic [$clog2(BANK):0]     rf_waddr,
    output logic [DW-1:0]             rf_wdata
);
    localparam int IW              = $clog2(BANK);
    localparam int RW              = IW + 1;
    localparam int STEP            = DW / 8;
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    state_t          state_q, state_d;
    logic [BANK-1:0] mask_q;
    logic            hi_q, pop_q, wb_q;
    logic [AW-1:0]   sp_q;
    logic [IW-1:0]   idx_up, idx_down, cur_idx;
    logic [BANK-1:0] mask_rest;
    logic [RW-1:0]   reg_num;
    logic            accept, step, is_pop, is_hi;

    assign is_pop  = ~cmd_op[1];
    assign is_hi   = cmd_op[0];
    assign accept  = cmd_valid && (state_q == ST_IDLE) && (cmd_op[7:2] == CMD_FAMILY);
    assign step    = (state_q == ST_XFER) && mem_ready;

    regstack_pick #(.W(BANK), .LOW_FIRST(1'b1)) u_pick_up (
        .mask (mask_q),
        .idx  (idx_up)
    );

    regstack_pick #(.W(BANK), .LOW_FIRST(1'b0)) u_pick_down (
        .mask (mask_q),
        .idx  (idx_down)
    );

    assign cur_idx   = pop_q ? idx_up : idx_down;
    assign reg_num   = {hi_q, cur_idx};
    assign mask_rest = mask_q & ~(BANK'(1) << cur_idx);

    regstack_sp #(.AW(AW), .STEP(STEP)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sp_in),
        .inc      (step && pop_q),
        .dec      (step && !pop_q),
        .sp       (sp_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (|cmd_mask) ? ST_XFER : ST_FINISH;  // T_ACCEPT / T_EMPTY
            end
            ST_XFER: begin
                if (step && (mask_rest == '0)) state_d = ST_FINISH;      // T_LAST
            end
            ST_FINISH: state_d = ST_IDLE;                                 // T_RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            hi_q    <= 1'b0;
            pop_q   <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mask_q <= cmd_mask;
                hi_q   <= is_hi;
                pop_q  <= is_pop;
                wb_q   <= (|cmd_mask) && !(is_pop && is_hi && cmd_mask[BANK-1]);
            end else if (step) begin
                mask_q <= mask_rest;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mem_req   = (state_q == ST_XFER);
        mem_we    = (state_q == ST_XFER) && !pop_q;
        mem_addr  = pop_q ? sp_q : (sp_q - STEP_V);
        mem_wdata = rf_rdata;
        rf_raddr  = reg_num;
        rf_we     = 1'b0;
        rf_waddr  = reg_num;
        rf_wdata  = mem_rdata;
        unique case (state_q)
            ST_XFER:   rf_we = pop_q && mem_ready;
            ST_FINISH: begin
                rf_we    = wb_q;
                rf_waddr = '1;
                rf_wdata = DW'(sp_q);
            end
            default:   rf_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/regstack_chk.sv
module regstack_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic [DW-1:0] mem_rdata,
    input logic          rf_we,
    input logic [DW-1:0] rf_wdata
);
    p_bad_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op[7:2] != 6'b100011)) |=> !busy);

    p_pop_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |-> (rf_we && rf_wdata == mem_rdata));

    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=>
            (!mem_req || mem_addr == $past(mem_addr) + 32'd4));

    p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we) |=>
            (!mem_req || mem_addr == $past(mem_addr) - 32'd4));

    p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !done));
endmodule

bind regstack_seq regstack_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata)
);

// File: tb/tb_regstack_seq.sv
`timescale 1ns/1ps
module tb_regstack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [7:0]  cmd_mask = 8'h00;
    logic        busy, done;
    logic [31:0] sp_in;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;

    logic [31:0] regs [16];
    logic [31:0] mem  [64];
    logic [31:0] saved [16];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cycles   = 0;
    bit          stall_mode = 1'b0;
    bit          poke       = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          r_busy, r_done, r_req;

    localparam logic [31:0] SP0 = 32'h0000_0180;

    always #2.5 clk = ~clk;

    regstack_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .busy(busy), .done(done), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign rf_rdata  = regs[rf_raddr];
    assign sp_in     = regs[15];
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (rf_we) regs[rf_waddr] <= rf_wdata;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[7:2]] <= mem_wdata;
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (stall_mode) mem_ready <= lfsr[0];
        else            mem_ready <= 1'b1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] m);
        int guard;
        r_busy = 0; r_done = 0; r_req = 0; guard = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask = m;
        @(negedge clk);
        if (poke) begin cmd_op = 8'h8D; cmd_mask = 8'hFF; end
        else cmd_valid = 1'b0;
        while (busy && guard < 2000) begin
            r_busy++;
            if (done) r_done++;
            if (mem_req) r_req++;
            if (done) cmd_valid = 1'b0;
            guard++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic fill_regs(input logic [7:0] tag);
        for (int i = 0; i < 15; i++) regs[i] = {8'hA0, tag, 8'h00, 8'(i)};
        regs[15] = SP0;
    endtask

    task automatic sweep_one(input bit hi, input logic [7:0] m);
        int          n, k;
        logic [31:0] base, v;
        bit          ok;
        n = $countones(m);
        @(negedge clk);
        fill_regs(m);
        for (int i = 0; i < 16; i++) saved[i] = regs[i];
        for (int i = 0; i < 64; i++) mem[i] = 32'h5555_0000 | i;
        run_cmd({7'b1000111, hi}, m);
        check(r_done == 1, "R10 done once (push)", r_done, 1);
        if (!stall_mode) check(r_busy == n + 1, "R9 push busy cycles", r_busy, n + 1);
        if (n == 0) check(r_req == 0, "R7 empty push requests", r_req, 0);
        base = SP0 - 32'(4 * n);
        check(regs[15] == base, "R6 push final R15", regs[15], base);
        ok = 1'b1; k = 0; v = 32'h0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                v = saved[{hi, 3'(i)}];
                if (mem[(base[7:2] + 6'(k))] !== v) ok = 1'b0;
                k++;
            end
        end
        check(ok, "R4/R2 push memory layout", mem[base[7:2]], saved[{hi, 3'd0}]);
        for (int i = 0; i < 8; i++) if (!(hi && i == 7)) regs[{hi, 3'(i)}] = 32'hDEAD_0000 | i;
        run_cmd({7'b1000110, hi}, m);
        check(r_done == 1, "R10 done once (pop)", r_done, 1);
        if (!stall_mode) check(r_busy == n + 1, "R9 pop busy cycles", r_busy, n + 1);
        ok = 1'b1;
        for (int i = 0; i < 8; i++)
            if (m[i] && regs[{hi, 3'(i)}] !== saved[{hi, 3'(i)}]) ok = 1'b0;
        check(ok, "R5/R3 pop restores registers", regs[{hi, 3'd0}], saved[{hi, 3'd0}]);
        check(regs[15] == SP0, "R3/R6 pop final R15", regs[15], SP0);
    endtask

    initial begin
        fill_regs(8'h00);
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !rf_we, "R10 reset state", {busy, done, mem_req, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: codes outside the family are ignored
        fill_regs(8'h11);
        run_cmd(8'h8B, 8'hFF);
        check(r_busy == 0 && regs[15] == SP0, "R1 code 0x8B ignored", r_busy, 0);
        run_cmd(8'h90, 8'hFF);
        check(r_busy == 0 && regs[15] == SP0, "R1 code 0x90 ignored", r_busy, 0);
        run_cmd(8'h0C, 8'h01);
        check(r_busy == 0 && regs[0] == 32'hA011_0000, "R1 code 0x0C ignored", regs[0], 32'hA011_0000);

        // R7: empty mask, one cycle, R15 unchanged
        run_cmd(8'h8C, 8'h00);
        check(r_busy == 1 && r_req == 0 && r_done == 1, "R7 empty pop", r_busy, 1);
        check(regs[15] == SP0, "R7 empty pop keeps R15", regs[15], SP0);

        // Exhaustive sweep over both halves and every mask (R2..R6, R9, R10)
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 256; m++)
                sweep_one(b[0], 8'(m));

        // R8: R15 in a pop list takes the loaded word
        @(negedge clk);
        regs[15] = SP0;
        mem[SP0[7:2]] = 32'h0000_0240;
        run_cmd(8'h8D, 8'h80);
        check(regs[15] == 32'h0000_0240, "R8 R15 loaded overrides", regs[15], 32'h0000_0240);
        regs[15] = SP0;
        mem[SP0[7:2]] = 32'h1234_5678;
        mem[SP0[7:2] + 6'd1] = 32'h0000_0300;
        run_cmd(8'h8D, 8'h81);
        check(regs[8] == 32'h1234_5678, "R8 R8 popped before R15", regs[8], 32'h1234_5678);
        check(regs[15] == 32'h0000_0300, "R8 R15 final after R8", regs[15], 32'h0000_0300);

        // R6: misaligned pointer is aligned before use
        fill_regs(8'h22);
        regs[15] = SP0 | 32'h3;
        run_cmd(8'h8E, 8'h01);
        check(regs[15] == SP0 - 32'd4, "R6 aligned push pointer", regs[15], SP0 - 32'd4);
        check(mem[(SP0[7:2] - 6'd1)] == 32'hA022_0000, "R6 aligned push address",
              mem[(SP0[7:2] - 6'd1)], 32'hA022_0000);

        // R9 + R10: stalled memory, with a competing command held while busy
        stall_mode = 1'b1;
        poke = 1'b1;
        sweep_one(1'b1, 8'h5A);
        sweep_one(1'b0, 8'hC3);
        poke = 1'b0;
        sweep_one(1'b1, 8'hFF);
        stall_mode = 1'b0;

        summary();
    end
endmodule